// File: doc/BRIEF.md
# Timer Update-Event Core

This block is a 16-bit general-purpose timer core whose central job is deciding when an update event happens. A prescaler divides the clock by a programmable factor. A main counter then counts up, down, or up-then-down (center-aligned) against an auto-reload limit. An update event comes from one of three causes: the counter wrapping at either end, a software generate request, or a pulse on the external trigger input. Two control bits choose which of these causes set the sticky update flag. The interrupt output is the flag gated by an enable bit.

Software reaches the core through a single-cycle register bus. A write takes effect at the clock edge where the write strobe is sampled. A read returns its data, with a valid strobe, one cycle after the read strobe. The control word is laid out as follows: bit 0 is count enable, bit 1 is update-disable, bit 2 is update-source-select, bits 4:3 are the count mode (0 up, 1 down, 2 or 3 center-aligned), and bit 8 is interrupt enable. All other control bits read 0.

Top module: `upd_timer`

## Requirements
- R1: After reset, reads give control (0x00) = 0, status (0x10) = 0, event-generate (0x14) = 0, counter (0x24) = 0, prescale (0x28) = 0 and reload (0x2C) = 0xFFFF. Read data and `bus_rvalid` appear one cycle after `bus_re`.
- R2: Status bit 0 is the update flag. Writing 0 to it clears the flag, and writing 1 leaves it unchanged. Status bits 15:1 read 0.
- R3: Writing 1 to event-generate bit 0 reinitialises the counter and raises an update. The register always reads 0.
- R4: A reinitialisation loads the reload value in down mode and 0 in up or center mode. It also clears the prescaler's internal count, while the programmed prescale value reads back unchanged.
- R5: While count enable is 1, the counter advances once every prescale+1 clocks.
- R6: In up mode, the counter counts to the reload value and then wraps to 0. With update-disable 0, that wrap sets the flag.
- R7: In down mode, the counter counts to 0 and then reloads. With update-disable 0, that underflow sets the flag.
- R8: In center mode, the counter rises to the reload value, turns and falls to 0, then turns again. Each turn sets the flag when update-disable is 0.
- R9: With update-source-select 1, only counter wraps set the flag. Software and trigger reinitialisations still reload the counter.
- R10: With update-disable 1, no cause sets the flag. Software and trigger requests still reinitialise the counter.
- R11: A one-cycle pulse on `trig_i` reinitialises the counter in the same way as R4. It sets the flag when both update-disable and update-source-select are 0.
- R12: `irq_o` is a registered output equal to the update flag ANDed with control bit 8.
- R13: The counter register is readable and writable. A reinitialisation in the same cycle takes priority over a bus write, and a bus write takes priority over a count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | W (16) | Write data |
| bus_rdata | output | W (16) | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_re` |
| trig_i | input | 1 | External reinitialisation trigger |
| irq_o | output | 1 | Update interrupt request |

## Verification
The bench builds the core at its default 16-bit counter and 8-bit address widths. It programs small reload values (3, 5 and 100) and prescale factors of 0, 2 and 3, so that every wrap, every center-mode turn, and prescaler residue left over from an earlier run are all reached within a few dozen clocks. Because both the residue and a same-cycle clash between a trigger and a counter write are set up on purpose, the ordering rules of R4 and R13 can be told apart at the ports.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_CTR  = 2'd2,
    MODE_CTRB = 2'd3
  } cnt_mode_e;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STS  = 'h10;
  localparam int OFS_EGR  = 'h14;
  localparam int OFS_CNT  = 'h24;
  localparam int OFS_PSC  = 'h28;
  localparam int OFS_ARR  = 'h2C;

  localparam int CB_CEN  = 0;
  localparam int CB_UD   = 1;
  localparam int CB_URS  = 2;
  localparam int CB_MLO  = 3;
  localparam int CB_MHI  = 4;
  localparam int CB_UIE  = 8;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] pc_q;
  logic         at_top;

  always_comb begin
    at_top = (pc_q >= div);
    tick   = run && !clr && at_top;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (clr) begin
      pc_q <= '0;
    end else if (run) begin
      if (at_top) pc_q <= '0;
      else        pc_q <= pc_q + 1'b1;
    end
  end

  // R4: a reinitialisation leaves the internal count at zero
  a_r4_psc_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pc_q == '0));

  // R5: a step pulse restarts the division window
  a_r5_tick_restarts: assert property (@(posedge clk) disable iff (rst)
    tick |=> (pc_q == '0));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         reinit,
  input  cnt_mode_e    mode,
  input  logic [W-1:0] arr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_n;
  logic         dn_q, dn_n;
  logic         arr_zero;

  assign arr_zero = (arr == '0);

  always_comb begin
    cnt_n = cnt_q;
    dn_n  = dn_q;
    wrap  = 1'b0;
    if (reinit) begin
      cnt_n = (mode == MODE_DOWN) ? arr : '0;
      dn_n  = 1'b0;
    end else if (wr_en) begin
      cnt_n = wr_val;
    end else if (tick) begin
      unique case (mode)
        MODE_UP: begin
          if (cnt_q >= arr) begin
            cnt_n = '0;
            wrap  = 1'b1;
          end else begin
            cnt_n = cnt_q + ONE;
          end
        end
        MODE_DOWN: begin
          if (cnt_q == '0) begin
            cnt_n = arr;
            wrap  = 1'b1;
          end else begin
            cnt_n = cnt_q - ONE;
          end
        end
        default: begin
          if (!dn_q) begin
            if (cnt_q >= arr) begin
              cnt_n = arr_zero ? '0 : arr - ONE;
              dn_n  = 1'b1;
              wrap  = 1'b1;
            end else begin
              cnt_n = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_n = arr_zero ? '0 : ONE;
              dn_n  = 1'b0;
              wrap  = 1'b1;
            end else begin
              cnt_n = cnt_q - ONE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      dn_q  <= dn_n;
    end
  end

  assign cnt = cnt_q;

  // R4: down-mode reinitialisation loads the reload value
  a_r4_reinit_down: assert property (@(posedge clk) disable iff (rst)
    (reinit && mode == MODE_DOWN) |=> (cnt_q == $past(arr)));

  // R4: up-mode reinitialisation clears the counter
  a_r4_reinit_up: assert property (@(posedge clk) disable iff (rst)
    (reinit && mode == MODE_UP) |=> (cnt_q == '0));

  // R13: a bus write without a reinitialisation lands as written
  a_r13_bus_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !reinit) |=> (cnt_q == $past(wr_val)));
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          bus_rvalid,
  input  logic          trig_i,
  input  logic [W-1:0]  cnt_i,
  input  logic          wrap_i,
  output logic          cen_o,
  output cnt_mode_e     mode_o,
  output logic [W-1:0]  arr_o,
  output logic [W-1:0]  psc_o,
  output logic          reinit_o,
  output logic          cnt_we_o,
  output logic [W-1:0]  cnt_wval_o,
  output logic          irq_o
);
  localparam logic [W-1:0] CTRL_MASK =
    W'((1 << CB_CEN) | (1 << CB_UD) | (1 << CB_URS) |
       (1 << CB_MLO) | (1 << CB_MHI) | (1 << CB_UIE));

  logic [W-1:0] ctrl_q, ctrl_n;
  logic [W-1:0] psc_q, arr_q;
  logic         uif_q, uif_n, irq_q;
  logic         hit_ctrl, hit_sts, hit_egr, hit_cnt, hit_psc, hit_arr;
  logic         sw_gen, flag_set, flag_clr;
  logic [W-1:0] rd_mux;

  always_comb begin
    hit_ctrl = (bus_addr == AW'(OFS_CTRL));
    hit_sts  = (bus_addr == AW'(OFS_STS));
    hit_egr  = (bus_addr == AW'(OFS_EGR));
    hit_cnt  = (bus_addr == AW'(OFS_CNT));
    hit_psc  = (bus_addr == AW'(OFS_PSC));
    hit_arr  = (bus_addr == AW'(OFS_ARR));
  end

  always_comb begin
    sw_gen   = bus_we && hit_egr && bus_wdata[0];
    reinit_o = sw_gen || trig_i;
    flag_set = !ctrl_q[CB_UD] && (wrap_i || (!ctrl_q[CB_URS] && reinit_o));
    flag_clr = bus_we && hit_sts && !bus_wdata[0];
    uif_n    = flag_set ? 1'b1 : (flag_clr ? 1'b0 : uif_q);
    ctrl_n   = (bus_we && hit_ctrl) ? (bus_wdata & CTRL_MASK) : ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      arr_q  <= '1;
      uif_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      uif_q  <= uif_n;
      irq_q  <= uif_n && ctrl_n[CB_UIE];
      if (bus_we && hit_psc) psc_q <= bus_wdata;
      if (bus_we && hit_arr) arr_q <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux = ctrl_q;
    if (hit_sts)  rd_mux = {{(W-1){1'b0}}, uif_q};
    if (hit_cnt)  rd_mux = cnt_i;
    if (hit_psc)  rd_mux = psc_q;
    if (hit_arr)  rd_mux = arr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) bus_rdata <= rd_mux;
    end
  end

  assign cen_o      = ctrl_q[CB_CEN];
  assign mode_o     = cnt_mode_e'(ctrl_q[CB_MHI:CB_MLO]);
  assign arr_o      = arr_q;
  assign psc_o      = psc_q;
  assign cnt_we_o   = bus_we && hit_cnt;
  assign cnt_wval_o = bus_wdata;
  assign irq_o      = irq_q;

  // R2: the flag stays set unless software writes a 0 to it
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (uif_q && !(bus_we && hit_sts && !bus_wdata[0])) |=> uif_q);

  // R3: the event-generate register never reads back a 1
  a_r3_egr_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && hit_egr) |=> (bus_rdata == '0));

  // R9: with source-select set, only a wrap can raise the flag
  a_r9_source_select: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_URS] && !uif_q && !wrap_i) |=> !uif_q);

  // R10: update-disable keeps the flag low
  a_r10_update_disable: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_UD] && !uif_q) |=> !uif_q);

  // R12: the interrupt line follows flag and enable
  a_r12_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq_q == (uif_q && ctrl_q[CB_UIE]));
endmodule

// File: rtl/upd_timer.sv
`timescale 1ns/1ps
module upd_timer
  import tmr_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          bus_rvalid,
  input  logic          trig_i,
  output logic          irq_o
);
  logic         cen, reinit, tick, wrap, cnt_we;
  cnt_mode_e    mode;
  logic [W-1:0] arr, psc, cnt, cnt_wval;

  tmr_regs #(.W(W), .AW(AW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .trig_i     (trig_i),
    .cnt_i      (cnt),
    .wrap_i     (wrap),
    .cen_o      (cen),
    .mode_o     (mode),
    .arr_o      (arr),
    .psc_o      (psc),
    .reinit_o   (reinit),
    .cnt_we_o   (cnt_we),
    .cnt_wval_o (cnt_wval),
    .irq_o      (irq_o)
  );

  tmr_prescaler #(.W(W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .run  (cen),
    .clr  (reinit),
    .div  (psc),
    .tick (tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .reinit (reinit),
    .mode   (mode),
    .arr    (arr),
    .wr_en  (cnt_we),
    .wr_val (cnt_wval),
    .cnt    (cnt),
    .wrap   (wrap)
  );
endmodule

// File: tb/sim_upd_timer.sv
`timescale 1ns/1ps
module sim_upd_timer;
  localparam int W  = 16;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_CTRL = 8'h00, A_STS = 8'h10, A_EGR = 8'h14,
                            A_CNT = 8'h24, A_PSC = 8'h28, A_ARR = 8'h2C;
  localparam logic [W-1:0] C_EN = 16'h0001, C_UD = 16'h0002, C_URS = 16'h0004,
                           C_DOWN = 16'h0008, C_CTR = 16'h0010, C_UIE = 16'h0100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0, bus_re = 1'b0, trig_i = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          bus_rvalid, irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [W-1:0] v;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  upd_timer #(.W(W), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .trig_i(trig_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every returned read
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sb.size() == 0) begin
        chk("R1 unexpected read data", bus_rdata, 'x);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, bus_rdata, e.v);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [W-1:0] e, input string tag);
    exp_t x;
    x.v = e; x.tag = tag;
    sb.push_back(x);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  // enable for k+1 counting edges, leaving ctrl at 'off' afterwards
  task automatic run(input logic [W-1:0] on, input logic [W-1:0] off, input int k);
    wr(A_CTRL, on);
    repeat (k) @(negedge clk);
    wr(A_CTRL, off);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    rd(A_CTRL, 16'h0000, "R1 ctrl reset");
    rd(A_STS,  16'h0000, "R1 status reset");
    rd(A_EGR,  16'h0000, "R1 egr reset");
    rd(A_CNT,  16'h0000, "R1 cnt reset");
    rd(A_PSC,  16'h0000, "R1 psc reset");
    rd(A_ARR,  16'hFFFF, "R1 reload reset");
    chk("R12 irq reset", {15'b0, irq_o}, 16'h0);

    // R5/R6 plain up count, divide by 1: 10 edges
    wr(A_ARR, 16'd100);
    run(C_EN, 16'h0, 9);
    rd(A_CNT, 16'd10, "R5 up count psc0");

    // R13 counter write
    wr(A_CNT, 16'h1234);
    rd(A_CNT, 16'h1234, "R13 cnt write");

    // R3/R4 software generate
    wr(A_PSC, 16'd2);
    wr(A_EGR, 16'h0001);
    rd(A_EGR, 16'h0000, "R3 egr reads 0");
    rd(A_CNT, 16'h0000, "R4 up reinit to 0");
    rd(A_PSC, 16'd2, "R4 prescale kept");
    rd(A_STS, 16'h0001, "R3 sw update flag");
    wr(A_STS, 16'h0001);
    rd(A_STS, 16'h0001, "R2 write 1 keeps");
    wr(A_STS, 16'h0000);
    rd(A_STS, 16'h0000, "R2 write 0 clears");

    // R5 divide by 3: 12 edges -> 4 steps
    run(C_EN, 16'h0, 11);
    rd(A_CNT, 16'd4, "R5 divide by 3");

    // R4 prescaler residue cleared by generate
    wr(A_PSC, 16'd3);
    wr(A_EGR, 16'h0001);
    wr(A_STS, 16'h0000);
    run(C_EN, 16'h0, 5);
    rd(A_CNT, 16'd1, "R5 divide by 4");
    wr(A_EGR, 16'h0001);
    wr(A_STS, 16'h0000);
    run(C_EN, 16'h0, 2);
    rd(A_CNT, 16'd0, "R4 residue cleared");

    // R6/R12 up wrap with interrupt enabled
    wr(A_PSC, 16'd0);
    wr(A_ARR, 16'd5);
    wr(A_EGR, 16'h0001);
    wr(A_STS, 16'h0000);
    run(C_EN | C_UIE, C_UIE, 5);
    rd(A_CNT, 16'd0, "R6 wrap to 0");
    rd(A_STS, 16'h0001, "R6 overflow flag");
    chk("R12 irq on", {15'b0, irq_o}, 16'h1);
    wr(A_STS, 16'h0000);
    @(negedge clk);
    chk("R12 irq cleared", {15'b0, irq_o}, 16'h0);

    // R7 down mode
    wr(A_CTRL, C_DOWN);
    wr(A_EGR, 16'h0001);
    rd(A_CNT, 16'd5, "R4 down reinit to reload");
    wr(A_STS, 16'h0000);
    run(C_EN | C_DOWN, C_DOWN, 6);
    rd(A_CNT, 16'd4, "R7 down after underflow");
    rd(A_STS, 16'h0001, "R7 underflow flag");
    chk("R12 irq gated off", {15'b0, irq_o}, 16'h0);
    wr(A_STS, 16'h0000);

    // R9 source select
    wr(A_CTRL, C_URS);
    wr(A_CNT, 16'd3);
    wr(A_EGR, 16'h0001);
    rd(A_CNT, 16'd0, "R9 sw reinit still loads");
    rd(A_STS, 16'h0000, "R9 sw no flag");
    wr(A_CNT, 16'd3);
    pulse_trig();
    rd(A_CNT, 16'd0, "R9 trig reinit still loads");
    rd(A_STS, 16'h0000, "R9 trig no flag");
    run(C_EN | C_URS, C_URS, 5);
    rd(A_STS, 16'h0001, "R9 overflow flag");
    wr(A_STS, 16'h0000);

    // R10 update disable
    wr(A_CTRL, C_UD);
    wr(A_CNT, 16'd3);
    wr(A_EGR, 16'h0001);
    rd(A_CNT, 16'd0, "R10 sw reinit still loads");
    rd(A_STS, 16'h0000, "R10 sw no flag");
    run(C_EN | C_UD, C_UD, 5);
    rd(A_CNT, 16'd0, "R10 wrapped");
    rd(A_STS, 16'h0000, "R10 overflow no flag");
    wr(A_CNT, 16'd2);
    pulse_trig();
    rd(A_CNT, 16'd0, "R10 trig reinit");
    rd(A_STS, 16'h0000, "R10 trig no flag");

    // R11 trigger
    wr(A_CTRL, 16'h0000);
    wr(A_CNT, 16'd7);
    pulse_trig();
    rd(A_CNT, 16'd0, "R11 trig up reinit");
    rd(A_STS, 16'h0001, "R11 trig flag");
    wr(A_STS, 16'h0000);
    wr(A_CTRL, C_DOWN);
    wr(A_CNT, 16'd1);
    pulse_trig();
    rd(A_CNT, 16'd5, "R11 trig down reinit");
    wr(A_STS, 16'h0000);

    // R13 trigger beats a same-cycle counter write
    wr(A_CTRL, 16'h0000);
    trig_i = 1'b1;
    wr(A_CNT, 16'h0055);
    trig_i = 1'b0;
    rd(A_CNT, 16'd0, "R13 reinit over write");
    wr(A_STS, 16'h0000);

    // R8 center mode
    wr(A_CTRL, C_CTR);
    wr(A_ARR, 16'd3);
    wr(A_EGR, 16'h0001);
    wr(A_STS, 16'h0000);
    run(C_EN | C_CTR, C_CTR, 4);
    rd(A_CNT, 16'd1, "R8 center falling");
    rd(A_STS, 16'h0001, "R8 top turn flag");
    wr(A_STS, 16'h0000);
    run(C_EN | C_CTR, C_CTR, 2);
    rd(A_CNT, 16'd2, "R8 center rising again");
    rd(A_STS, 16'h0001, "R8 bottom turn flag");

    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", 16'(sb.size()), 16'h0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule